// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Unit

This unit sits behind a CAN bus receiver that has already decoded a complete, valid frame. The receiver hands over one frame at a time through a ready/valid handshake. Each frame carries a 29-bit identifier, an extended-format flag, a remote-request flag, a length code and eight data bytes. The unit then looks for the mailbox that should take the frame. It checks one mailbox per clock cycle, starting at mailbox 15 and counting down, and stops at the first one that is enabled, has the same format and request flags, and agrees with the frame identifier on every bit that its acceptance mask does not ignore.

Each mailbox has a policy for a frame that arrives while its previous frame is still pending. Under the replace policy the new frame overwrites the stored one. Under the keep policy the new frame is dropped and the stored frame stays. In both cases an unread-message flag and a separate interrupt source record the event. The unit keeps per-mailbox flags for data-pending, remote-pending and unread-message, and three interrupt request bits. Each request can be blocked per mailbox, and the interrupt line can be gated per source. A small CPU register port configures the mailboxes, reads back stored frames and clears flags by writing 1.

Top module: `can_rx_accept`

## Requirements
- R1: `frm_ready` is high only while the unit is idle. A frame is taken on a clock edge where `frm_valid` and `frm_ready` are both high. `frm_ready` is low in the cycle after acceptance, and a frame held valid during a search is taken after that search ends.
- R2: A mailbox is a candidate only when its enable bit is 1 and its IDE and RTR configuration bits equal those of the frame. On every identifier bit where the mailbox mask bit is 0, the frame identifier must equal the mailbox identifier. Identifier bits whose mask bit is 1 are not compared.
- R3: The search checks mailbox 15 first and then one lower index per cycle. The highest-numbered candidate wins. When mailbox k wins, its flags and contents are updated, and `frm_ready` rises again, on the (16-k)th rising edge after acceptance.
- R4: When no mailbox matches, the frame is dropped after the 16th edge and no flag, interrupt request or stored content changes.
- R5: If the winner's pending flag for the frame type is clear, the unit stores the length code and data. A data frame (RTR 0) then sets the data-pending bit and interrupt request bit 0. A remote frame (RTR 1) sets the remote-pending bit and request bit 1. The request bit is set only if the mailbox interrupt-block bit is 0.
- R6: If that pending flag is already set and the replace bit is 1, the new frame overwrites the stored contents. The unread-message bit and request bit 2 are set, and the pending flag stays set.
- R7: If that pending flag is already set and the replace bit is 0, the stored contents stay unchanged. The unread-message bit and request bit 2 are still set.
- R8: `irq` is high while any request bit is 1 and its global gate bit is 0. A mailbox whose interrupt-block bit is 1 raises no request bit.
- R9: Writing 1 to a bit of the data-pending, remote-pending, unread-message or request register clears that bit, and writing 0 has no effect. A hardware set in the same cycle as a clear wins. The bench therefore accepts a pending bit that is set again by a keep-policy event.
- R10: Register map (byte-free word addresses). Mailbox m uses addresses {0,m[3:0],s[2:0]}:
  - s=0: bit31 enable, bit30 RTR, bit29 IDE, bits28:0 identifier.
  - s=1: bits28:0 mask.
  - s=2: bit0 replace, bit1 interrupt block, bits11:8 stored length code (read-only).
  - s=3: stored bytes 0..3, byte i at bits 8i+7:8i (read-only).
  - s=4: stored bytes 4..7 (read-only).
  - Global registers: 0x80 data-pending, 0x81 remote-pending, 0x82 unread-message, 0x83 requests (bit0 data, bit1 remote, bit2 unread), 0x84 gate bits 2:0.
  - Frame byte i is `frm_data[8i+7:8i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Decoded frame offered |
| frm_ready | output | 1 | Unit idle, frame taken this edge if valid |
| frm_id | input | 29 | Frame identifier |
| frm_ide | input | 1 | Extended-format flag of frame |
| frm_rtr | input | 1 | Remote-request flag of frame |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Data bytes |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 8 | Register word address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data (combinational on address) |
| irq | output | 1 | Interrupt line |

## Verification
The bench sends a matching frame to each of the sixteen mailboxes in turn. The latency it measures tells whether the search runs downward one step per cycle, and the flag readback shows the correct winner. Frames that hit two all-ignoring mailboxes at once, a disabled mailbox, a partial mask, or a mismatched IDE or RTR flag separate priority from filtering. Frames sent twice to the same mailbox tell the replace policy from the keep policy by the stored data read back. Blocked, gated and zero-written cases show that masks and clears act only where the requirements say.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  localparam int ID_W   = 29;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;
  localparam int REG_W  = 32;
  localparam int IRQ_N  = 3;

  // mailbox register selectors
  localparam logic [2:0] SEL_ID   = 3'd0;
  localparam logic [2:0] SEL_MASK = 3'd1;
  localparam logic [2:0] SEL_CTRL = 3'd2;
  localparam logic [2:0] SEL_DLO  = 3'd3;
  localparam logic [2:0] SEL_DHI  = 3'd4;
  // global register selectors
  localparam logic [2:0] GSEL_RXP  = 3'd0;
  localparam logic [2:0] GSEL_RFP  = 3'd1;
  localparam logic [2:0] GSEL_UMS  = 3'd2;
  localparam logic [2:0] GSEL_IRQ  = 3'd3;
  localparam logic [2:0] GSEL_GATE = 3'd4;

  typedef enum logic {SC_IDLE, SC_SCAN} scan_state_e;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ide;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } can_frame_t;
endpackage

// File: rtl/can_rx_match.sv
module can_rx_match
  import can_rx_pkg::*;
#(
  parameter int NUM_MB = 16
) (
  input  logic [ID_W-1:0]              frame_id,
  input  logic                         frame_ide,
  input  logic                         frame_rtr,
  input  logic [NUM_MB-1:0]            cfg_en,
  input  logic [NUM_MB-1:0]            cfg_ide,
  input  logic [NUM_MB-1:0]            cfg_rtr,
  input  logic [NUM_MB-1:0][ID_W-1:0]  cfg_id,
  input  logic [NUM_MB-1:0][ID_W-1:0]  cfg_mask,
  output logic [NUM_MB-1:0]            hit
);
  for (genvar g = 0; g < NUM_MB; g++) begin : g_cmp
    logic id_ok;
    assign id_ok  = ~|((frame_id ^ cfg_id[g]) & ~cfg_mask[g]);
    assign hit[g] = cfg_en[g] & (cfg_ide[g] == frame_ide) &
                    (cfg_rtr[g] == frame_rtr) & id_ok;
  end
endmodule

// File: rtl/can_rx_scan.sv
module can_rx_scan
  import can_rx_pkg::*;
#(
  parameter int NUM_MB = 16,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  can_frame_t        frame_in,
  input  logic [NUM_MB-1:0] hit,
  output can_frame_t        frame_q,
  output logic              commit,
  output logic [IDX_W-1:0]  win_idx
);
  scan_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             load;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    load    = 1'b0;
    commit  = 1'b0;
    case (state_q)
      SC_IDLE: begin
        if (frm_valid) begin
          load    = 1'b1;
          state_d = SC_SCAN;
          idx_d   = IDX_W'(NUM_MB - 1);
        end
      end
      default: begin
        if (hit[idx_q]) begin
          commit  = 1'b1;
          state_d = SC_IDLE;
        end else if (idx_q == '0) begin
          state_d = SC_IDLE;
        end else begin
          idx_d = idx_q - IDX_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      idx_q   <= '0;
      frame_q <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (load) frame_q <= frame_in;
    end
  end

  assign frm_ready = (state_q == SC_IDLE);
  assign win_idx   = idx_q;

  // R3
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SC_SCAN && !commit && idx_q != '0) |=>
      (state_q == SC_SCAN && idx_q == $past(idx_q) - IDX_W'(1)));

  // R1
  scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |=>
      (!frm_ready && idx_q == IDX_W'(NUM_MB - 1)));
endmodule

// File: rtl/can_rx_mbox_regs.sv
module can_rx_mbox_regs
  import can_rx_pkg::*;
#(
  parameter int NUM_MB = 16,
  localparam int IDX_W  = $clog2(NUM_MB),
  localparam int ADDR_W = IDX_W + 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [REG_W-1:0]             cpu_wdata,
  output logic [REG_W-1:0]             cpu_rdata,
  input  logic                         commit,
  input  logic [IDX_W-1:0]             win_idx,
  input  can_frame_t                   frame_q,
  output logic [NUM_MB-1:0]            cfg_en,
  output logic [NUM_MB-1:0]            cfg_ide,
  output logic [NUM_MB-1:0]            cfg_rtr,
  output logic [NUM_MB-1:0][ID_W-1:0]  cfg_id,
  output logic [NUM_MB-1:0][ID_W-1:0]  cfg_mask,
  output logic                         irq
);
  logic [NUM_MB-1:0]             en_q, en_d, ide_q, ide_d, rtr_q, rtr_d;
  logic [NUM_MB-1:0]             ovw_q, ovw_d, blk_q, blk_d;
  logic [NUM_MB-1:0][ID_W-1:0]   id_q, id_d, mask_q, mask_d;
  logic [NUM_MB-1:0][DLC_W-1:0]  dlc_q, dlc_d;
  logic [NUM_MB-1:0][DATA_W-1:0] data_q, data_d;
  logic [NUM_MB-1:0]             rxp_q, rxp_d, rfp_q, rfp_d, ums_q, ums_d;
  logic [IRQ_N-1:0]              req_q, req_d, gate_q, gate_d, req_set;

  logic              is_glb;
  logic [IDX_W-1:0]  mb_sel;
  logic [2:0]        reg_sel;
  logic              glb_we;
  logic [NUM_MB-1:0] win_oh, pend_vec, store_vec;
  logic [NUM_MB-1:0] clr_rxp, clr_rfp, clr_ums;
  logic [IRQ_N-1:0]  clr_req;
  logic              win_pend, win_blk;

  assign is_glb  = cpu_addr[ADDR_W-1];
  assign mb_sel  = cpu_addr[IDX_W+2:3];
  assign reg_sel = cpu_addr[2:0];
  assign glb_we  = cpu_we & is_glb;

  // winner decode and policy
  assign win_oh    = commit ? (NUM_MB'(1) << win_idx) : '0;
  assign pend_vec  = frame_q.rtr ? rfp_q : rxp_q;
  assign store_vec = win_oh & (~pend_vec | ovw_q);
  assign win_pend  = pend_vec[win_idx];
  assign win_blk   = blk_q[win_idx];

  assign req_set[0] = commit & ~frame_q.rtr & ~win_pend & ~win_blk;
  assign req_set[1] = commit &  frame_q.rtr & ~win_pend & ~win_blk;
  assign req_set[2] = commit &  win_pend & ~win_blk;

  // write-one-to-clear strobes
  assign clr_rxp = (glb_we && reg_sel == GSEL_RXP) ? cpu_wdata[NUM_MB-1:0] : '0;
  assign clr_rfp = (glb_we && reg_sel == GSEL_RFP) ? cpu_wdata[NUM_MB-1:0] : '0;
  assign clr_ums = (glb_we && reg_sel == GSEL_UMS) ? cpu_wdata[NUM_MB-1:0] : '0;
  assign clr_req = (glb_we && reg_sel == GSEL_IRQ) ? cpu_wdata[IRQ_N-1:0] : '0;

  // next state: flags (hardware set wins over clear)
  always_comb begin
    rxp_d  = (rxp_q & ~clr_rxp) | (frame_q.rtr ? '0 : win_oh);
    rfp_d  = (rfp_q & ~clr_rfp) | (frame_q.rtr ? win_oh : '0);
    ums_d  = (ums_q & ~clr_ums) | (win_oh & pend_vec);
    req_d  = (req_q & ~clr_req) | req_set;
    gate_d = (glb_we && reg_sel == GSEL_GATE) ? cpu_wdata[IRQ_N-1:0] : gate_q;
  end

  // next state: mailbox configuration and contents
  always_comb begin
    en_d   = en_q;   ide_d  = ide_q;  rtr_d  = rtr_q;
    id_d   = id_q;   mask_d = mask_q;
    ovw_d  = ovw_q;  blk_d  = blk_q;
    dlc_d  = dlc_q;  data_d = data_q;
    for (int m = 0; m < NUM_MB; m++) begin
      if (cpu_we && !is_glb && mb_sel == IDX_W'(m)) begin
        case (reg_sel)
          SEL_ID: begin
            en_d[m]  = cpu_wdata[31];
            rtr_d[m] = cpu_wdata[30];
            ide_d[m] = cpu_wdata[29];
            id_d[m]  = cpu_wdata[ID_W-1:0];
          end
          SEL_MASK: mask_d[m] = cpu_wdata[ID_W-1:0];
          SEL_CTRL: begin
            ovw_d[m] = cpu_wdata[0];
            blk_d[m] = cpu_wdata[1];
          end
          default: ;
        endcase
      end
      if (store_vec[m]) begin
        dlc_d[m]  = frame_q.dlc;
        data_d[m] = frame_q.data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0; ide_q  <= '0; rtr_q <= '0;
      id_q   <= '0; mask_q <= '0;
      ovw_q  <= '0; blk_q  <= '0;
      dlc_q  <= '0; data_q <= '0;
      rxp_q  <= '0; rfp_q  <= '0; ums_q <= '0;
      req_q  <= '0; gate_q <= '0;
    end else begin
      en_q   <= en_d;  ide_q  <= ide_d;  rtr_q <= rtr_d;
      id_q   <= id_d;  mask_q <= mask_d;
      ovw_q  <= ovw_d; blk_q  <= blk_d;
      dlc_q  <= dlc_d; data_q <= data_d;
      rxp_q  <= rxp_d; rfp_q  <= rfp_d;  ums_q <= ums_d;
      req_q  <= req_d; gate_q <= gate_d;
    end
  end

  // read mux
  always_comb begin
    cpu_rdata = '0;
    if (is_glb) begin
      case (reg_sel)
        GSEL_RXP:  cpu_rdata = REG_W'(rxp_q);
        GSEL_RFP:  cpu_rdata = REG_W'(rfp_q);
        GSEL_UMS:  cpu_rdata = REG_W'(ums_q);
        GSEL_IRQ:  cpu_rdata = REG_W'(req_q);
        GSEL_GATE: cpu_rdata = REG_W'(gate_q);
        default:   cpu_rdata = '0;
      endcase
    end else begin
      case (reg_sel)
        SEL_ID:   cpu_rdata = {en_q[mb_sel], rtr_q[mb_sel], ide_q[mb_sel], id_q[mb_sel]};
        SEL_MASK: cpu_rdata = REG_W'(mask_q[mb_sel]);
        SEL_CTRL: cpu_rdata = {20'b0, dlc_q[mb_sel], 6'b0, blk_q[mb_sel], ovw_q[mb_sel]};
        SEL_DLO:  cpu_rdata = data_q[mb_sel][31:0];
        SEL_DHI:  cpu_rdata = data_q[mb_sel][63:32];
        default:  cpu_rdata = '0;
      endcase
    end
  end

  assign irq      = |(req_q & ~gate_q);
  assign cfg_en   = en_q;
  assign cfg_ide  = ide_q;
  assign cfg_rtr  = rtr_q;
  assign cfg_id   = id_q;
  assign cfg_mask = mask_q;

  // R7
  keep_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && win_pend && !ovw_q[win_idx]) |=> (data_q == $past(data_q)));

  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !frame_q.rtr) |=> rxp_q[$past(win_idx)]);

  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_we && reg_sel == GSEL_RXP && !commit) |=>
      ((rxp_q & $past(cpu_wdata[NUM_MB-1:0])) == '0));

  // R8
  blk_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && blk_q[win_idx]) |=> ((req_q & ~$past(req_q)) == '0));
endmodule

// File: rtl/can_rx_accept.sv
module can_rx_accept
  import can_rx_pkg::*;
#(
  parameter int NUM_MB = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frm_valid,
  output logic                        frm_ready,
  input  logic [28:0]                 frm_id,
  input  logic                        frm_ide,
  input  logic                        frm_rtr,
  input  logic [3:0]                  frm_dlc,
  input  logic [63:0]                 frm_data,
  input  logic                        cpu_we,
  input  logic [$clog2(NUM_MB)+3:0]   cpu_addr,
  input  logic [31:0]                 cpu_wdata,
  output logic [31:0]                 cpu_rdata,
  output logic                        irq
);
  localparam int IDX_W = $clog2(NUM_MB);

  logic                        rst_s1, rst_s2;
  can_frame_t                  frame_in, frame_q;
  logic [NUM_MB-1:0]           hit, cfg_en, cfg_ide, cfg_rtr;
  logic [NUM_MB-1:0][ID_W-1:0] cfg_id, cfg_mask;
  logic                        commit;
  logic [IDX_W-1:0]            win_idx;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  assign frame_in = '{id: frm_id, ide: frm_ide, rtr: frm_rtr,
                      dlc: frm_dlc, data: frm_data};

  can_rx_scan #(.NUM_MB(NUM_MB)) u_scan (
    .clk(clk), .rst_n(rst_s2), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frame_in(frame_in), .hit(hit), .frame_q(frame_q),
    .commit(commit), .win_idx(win_idx)
  );

  can_rx_match #(.NUM_MB(NUM_MB)) u_match (
    .frame_id(frame_q.id), .frame_ide(frame_q.ide), .frame_rtr(frame_q.rtr),
    .cfg_en(cfg_en), .cfg_ide(cfg_ide), .cfg_rtr(cfg_rtr),
    .cfg_id(cfg_id), .cfg_mask(cfg_mask), .hit(hit)
  );

  can_rx_mbox_regs #(.NUM_MB(NUM_MB)) u_regs (
    .clk(clk), .rst_n(rst_s2), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .commit(commit),
    .win_idx(win_idx), .frame_q(frame_q), .cfg_en(cfg_en), .cfg_ide(cfg_ide),
    .cfg_rtr(cfg_rtr), .cfg_id(cfg_id), .cfg_mask(cfg_mask), .irq(irq)
  );

  // R2
  win_enabled_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    commit |-> (cfg_en[win_idx] && cfg_rtr[win_idx] == frame_q.rtr));
endmodule

// File: tb/can_rx_accept_tb.sv
module can_rx_accept_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frm_valid, frm_ready, frm_ide, frm_rtr;
  logic [28:0] frm_id;
  logic [3:0]  frm_dlc;
  logic [63:0] frm_data;
  logic        cpu_we;
  logic [7:0]  cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        irq;

  int n_vec  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  can_rx_accept u_dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_id(frm_id), .frm_ide(frm_ide), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
    .frm_data(frm_data), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int k);
    return {8{8'(k * 7 + 3)}} ^ 64'h0F1E2D3C4B5A6978;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic cfg_mb(input int m, input logic en, input logic rtr, input logic ide,
                        input logic [28:0] id, input logic [28:0] mask,
                        input logic ovw, input logic blk);
    wr({1'b0, 4'(m), 3'd0}, {en, rtr, ide, id});
    wr({1'b0, 4'(m), 3'd1}, {3'b0, mask});
    wr({1'b0, 4'(m), 3'd2}, {30'b0, blk, ovw});
  endtask

  task automatic cfg_default(input int m);
    cfg_mb(m, 1'b1, 1'b0, 1'b0, 29'(32'h100 + m), 29'h0, 1'b0, 1'b0);
  endtask

  task automatic clear_all();
    wr(8'h80, 32'hFFFF); wr(8'h81, 32'hFFFF);
    wr(8'h82, 32'hFFFF); wr(8'h83, 32'h7);
  endtask

  task automatic send(input logic [28:0] id, input logic ide, input logic rtr,
                      input logic [63:0] d, output int lat);
    @(negedge clk);
    frm_valid = 1'b1; frm_id = id; frm_ide = ide; frm_rtr = rtr;
    frm_dlc = 4'd8; frm_data = d;
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 1'b0;
    check("R1 ready low after accept", 64'(frm_ready), 64'd0);
    lat = 0;
    while (!frm_ready) begin
      @(negedge clk);
      lat++;
    end
  endtask

  logic [31:0] r;
  int lat;

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frm_valid = 1'b0; frm_id = '0; frm_ide = 1'b0; frm_rtr = 1'b0;
    frm_dlc = '0; frm_data = '0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R1 ready after reset", 64'(frm_ready), 64'd1);
    check("R8 irq after reset", 64'(irq), 64'd0);
    for (int a = 0; a < 4; a++) begin
      rd(8'(8'h80 + a), r);
      check("R10 global reg reset", 64'(r), 64'd0);
    end

    for (int m = 0; m < 16; m++) cfg_default(m);
    rd({1'b0, 4'd3, 3'd0}, r);
    check("R10 id word readback", 64'(r), 64'h8000_0103);

    // sweep: each mailbox wins alone
    for (int k = 0; k < 16; k++) begin
      send(29'(32'h100 + k), 1'b0, 1'b0, pat(k), lat);
      check("R3 latency per index", 64'(lat), 64'(16 - k));
      rd(8'h80, r); check("R5 data pending bit", 64'(r), 64'(1 << k));
      rd(8'h83, r); check("R5 data request bit", 64'(r), 64'd1);
      check("R8 irq raised", 64'(irq), 64'd1);
      rd({1'b0, 4'(k), 3'd3}, r); check("R5 stored low word", 64'(r), 64'(pat(k) & 64'hFFFF_FFFF));
      rd({1'b0, 4'(k), 3'd4}, r); check("R5 stored high word", 64'(r), 64'(pat(k) >> 32));
      rd({1'b0, 4'(k), 3'd2}, r); check("R10 stored length code", 64'(r), 64'h800);
      clear_all();
    end

    // no match
    send(29'h3FF, 1'b0, 1'b0, pat(40), lat);
    check("R4 no-match latency", 64'(lat), 64'd16);
    rd(8'h80, r); check("R4 no data pending", 64'(r), 64'd0);
    rd(8'h82, r); check("R4 no unread", 64'(r), 64'd0);
    rd(8'h83, r); check("R4 no request", 64'(r), 64'd0);

    // two ignore-all mailboxes: highest wins
    cfg_mb(3, 1'b1, 1'b0, 1'b0, 29'h0, 29'h1FFF_FFFF, 1'b0, 1'b0);
    cfg_mb(9, 1'b1, 1'b0, 1'b0, 29'h0, 29'h1FFF_FFFF, 1'b0, 1'b0);
    send(29'h3FF, 1'b0, 1'b0, pat(41), lat);
    check("R3 highest match latency", 64'(lat), 64'd7);
    rd(8'h80, r); check("R3 highest match wins", 64'(r), 64'(1 << 9));
    clear_all();
    cfg_mb(9, 1'b0, 1'b0, 1'b0, 29'h0, 29'h1FFF_FFFF, 1'b0, 1'b0);
    send(29'h3FF, 1'b0, 1'b0, pat(42), lat);
    check("R2 disabled skipped latency", 64'(lat), 64'd13);
    rd(8'h80, r); check("R2 disabled skipped", 64'(r), 64'(1 << 3));
    clear_all();
    cfg_default(3); cfg_default(9);

    // partial mask on mailbox 7 (low 4 bits ignored)
    cfg_mb(7, 1'b1, 1'b0, 1'b0, 29'h107, 29'h0F, 1'b0, 1'b0);
    send(29'h101, 1'b0, 1'b0, pat(43), lat);
    rd(8'h80, r); check("R2 masked bits ignored", 64'(r), 64'(1 << 7));
    clear_all();
    send(29'h11A, 1'b0, 1'b0, pat(44), lat);
    rd(8'h80, r); check("R2 unmasked bit compared", 64'(r), 64'd0);
    cfg_default(7);

    // qualifier mismatch
    send(29'h105, 1'b1, 1'b0, pat(45), lat);
    rd(8'h80, r); check("R2 IDE mismatch", 64'(r), 64'd0);
    send(29'h105, 1'b0, 1'b1, pat(46), lat);
    rd(8'h81, r); check("R2 RTR mismatch", 64'(r), 64'd0);

    // remote frame
    cfg_mb(5, 1'b1, 1'b1, 1'b0, 29'h105, 29'h0, 1'b0, 1'b0);
    send(29'h105, 1'b0, 1'b1, pat(47), lat);
    rd(8'h81, r); check("R5 remote pending bit", 64'(r), 64'(1 << 5));
    rd(8'h80, r); check("R5 no data pending on remote", 64'(r), 64'd0);
    rd(8'h83, r); check("R5 remote request bit", 64'(r), 64'd2);
    clear_all(); cfg_default(5);

    // replace policy
    cfg_mb(2, 1'b1, 1'b0, 1'b0, 29'h102, 29'h0, 1'b1, 1'b0);
    send(29'h102, 1'b0, 1'b0, pat(20), lat);
    send(29'h102, 1'b0, 1'b0, pat(21), lat);
    rd({1'b0, 4'd2, 3'd3}, r); check("R6 overwritten low word", 64'(r), 64'(pat(21) & 64'hFFFF_FFFF));
    rd(8'h82, r); check("R6 unread bit", 64'(r), 64'(1 << 2));
    rd(8'h80, r); check("R6 pending kept", 64'(r), 64'(1 << 2));
    rd(8'h83, r); check("R6 requests", 64'(r), 64'd5);
    clear_all();

    // keep policy
    send(29'h104, 1'b0, 1'b0, pat(30), lat);
    send(29'h104, 1'b0, 1'b0, pat(31), lat);
    rd({1'b0, 4'd4, 3'd4}, r); check("R7 kept high word", 64'(r), 64'(pat(30) >> 32));
    rd(8'h82, r); check("R7 unread bit", 64'(r), 64'(1 << 4));
    rd(8'h80, r); check("R7 pending kept", 64'(r), 64'(1 << 4));
    rd(8'h83, r); check("R7 requests", 64'(r), 64'd5);
    clear_all();

    // per-mailbox block and global gate
    cfg_mb(6, 1'b1, 1'b0, 1'b0, 29'h106, 29'h0, 1'b0, 1'b1);
    send(29'h106, 1'b0, 1'b0, pat(50), lat);
    rd(8'h80, r); check("R8 blocked still pending", 64'(r), 64'(1 << 6));
    rd(8'h83, r); check("R8 blocked no request", 64'(r), 64'd0);
    check("R8 blocked irq low", 64'(irq), 64'd0);
    clear_all(); cfg_default(6);
    send(29'h100, 1'b0, 1'b0, pat(51), lat);
    wr(8'h84, 32'h1);
    #1 check("R8 gated irq low", 64'(irq), 64'd0);
    wr(8'h84, 32'h0);
    #1 check("R8 ungated irq high", 64'(irq), 64'd1);

    // write-one-to-clear
    wr(8'h80, 32'h0);
    rd(8'h80, r); check("R9 zero write no effect pending", 64'(r), 64'd1);
    wr(8'h83, 32'h0);
    rd(8'h83, r); check("R9 zero write no effect request", 64'(r), 64'd1);
    wr(8'h80, 32'h1);
    rd(8'h80, r); check("R9 one write clears pending", 64'(r), 64'd0);
    wr(8'h83, 32'h1);
    rd(8'h83, r); check("R9 one write clears request", 64'(r), 64'd0);
    check("R9 irq low after clear", 64'(irq), 64'd0);

    // frame held during a search
    @(negedge clk);
    frm_valid = 1'b1; frm_id = 29'h10C; frm_ide = 1'b0; frm_rtr = 1'b0; frm_data = pat(60);
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_id = 29'h10D; frm_data = pat(61);
    check("R1 busy during search", 64'(frm_ready), 64'd0);
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 1'b0;
    while (!frm_ready) @(negedge clk);
    rd(8'h80, r); check("R1 held frame taken later", 64'(r), 64'((1 << 12) | (1 << 13)));
    rd({1'b0, 4'd13, 3'd3}, r); check("R1 held frame data", 64'(r), 64'(pat(61) & 64'hFFFF_FFFF));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule